// File: doc/BRIEF.md
# Full-Page Column Burst Sequencer

This block sits next to one SDRAM bank. It generates the column address for bursts whose length is set to a full page. The controller issues commands on a 3-bit opcode bus:

- ACTIVATE opens the bank.
- READ or WRITE, each with a start column, begins a burst.
- BURST STOP ends a burst.
- PRECHARGE closes the bank.

A full-page burst has no natural length. Once started, the sequencer steps through the page one column per clock and wraps modulo the page size. It keeps going until a stop, a precharge or a new READ or WRITE command ends or replaces it.

During a read burst the block raises a read-valid strobe. During a write burst it raises the internal write enable. It cuts a write off with no added latency: the clock edge that samples BURST STOP leaves the write enable low for the cycle that follows. It also counts how long the bank has been open. It flags an error when that time reaches a parameterised maximum activate-to-precharge count and no PRECHARGE has arrived.

All outputs are registered. A command sampled at a clock edge shows on the outputs right after that edge.

Top module: `fp_burst_seq`

## Requirements
- R1: While `rst` is high, and after it, every output is 0 (`col_addr`, `rd_valid`, `wr_en`, `busy`, `bank_open`, `ras_err`), until a command changes them.
- R2: Opcode 1 (ACTIVATE) sets `bank_open` after the edge. An ACTIVATE while the bank is already open is ignored: it does not restart the open-time count.
- R3: Opcode 2 (READ) or 3 (WRITE) with the bank open starts a burst. After that edge `col_addr` equals `cmd_col` and `busy` is 1, with `rd_valid` set for READ or `wr_en` set for WRITE.
- R4: On every edge during a burst with opcode 0 (NOP), `col_addr` advances by one modulo 256 (COL_W=8). The 256th advance brings it back to the start column.
- R5: A READ or WRITE during an active burst aborts it. After that edge the address is the new start column and the direction is the new one.
- R6: Opcode 4 (BURST STOP) ends a burst with zero latency: `rd_valid`, `wr_en` and `busy` are 0 right after the edge that samples it. A BURST STOP while idle has no effect.
- R7: Opcode 5 (PRECHARGE) ends any burst and clears `bank_open` and `ras_err` after the edge.
- R8: A READ or WRITE while the bank is closed is ignored: `busy`, `rd_valid` and `wr_en` stay 0.
- R9: `ras_err` rises at the TRAS_MAX-th edge after the ACTIVATE edge if no PRECHARGE has come. It stays 0 at the edge before that.
- R10: `rd_valid` and `wr_en` are never high together, and neither is high while the bank is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Opcode: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 BURST STOP, 5 PRECHARGE, 6–7 treated as NOP |
| cmd_col | input | COL_W | Start column for READ/WRITE |
| col_addr | output | COL_W | Column address of the current beat |
| rd_valid | output | 1 | Read beat active this cycle |
| wr_en | output | 1 | Internal write enable for this cycle |
| busy | output | 1 | A burst is in progress |
| bank_open | output | 1 | Bank is activated |
| ras_err | output | 1 | Bank open for TRAS_MAX cycles or more without PRECHARGE |

## Verification
The bound checker watches several rules on every cycle:
- the column steps by one on uninterrupted burst cycles;
- BURST STOP and PRECHARGE drop the strobes at the very next edge;
- a READ or WRITE to an open bank loads the start column;
- the two strobes are never high together, and never high with the bank closed.

The bench scenarios are what show the remaining behaviour:
- a full 256-beat walk that returns to the start column;
- the exact edge at which the open-time error rises;
- ACTIVATE, BURST STOP and READ being ignored in the states where they must be;
- recovery from reset in mid-burst.

// File: rtl/fp_burst_pkg.sv
package fp_burst_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_BST = 3'd4,
    OP_PRE = 3'd5
  } op_e;
endpackage

// File: rtl/fp_col_counter.sv
module fp_col_counter #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [COL_W-1:0] start_col,
  output logic [COL_W-1:0] col
);
  // modulo-2^COL_W wrap comes for free from the register width
  always_ff @(posedge clk) begin
    if (rst)       col <= '0;
    else if (load) col <= start_col;
    else if (step) col <= col + COL_W'(1);
  end
endmodule

// File: rtl/fp_tras_mon.sv
module fp_tras_mon #(
  parameter int TRAS_MAX = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic pre,
  output logic open_q,
  output logic err_q
);
  localparam int CNT_W = $clog2(TRAS_MAX + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TRAS_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = (cnt_q == LIMIT) ? cnt_q : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || pre) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else if (!open_q) begin
      if (act) begin
        open_q <= 1'b1;
        cnt_q  <= '0;
        err_q  <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_nx;
      err_q <= (cnt_nx >= LIMIT);
    end
  end
endmodule

// File: rtl/fp_burst_seq.sv
module fp_burst_seq
  import fp_burst_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int TRAS_MAX = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  output logic [COL_W-1:0] col_addr,
  output logic             rd_valid,
  output logic             wr_en,
  output logic             busy,
  output logic             bank_open,
  output logic             ras_err
);
  op_e  op;
  logic is_act, is_rd, is_wr, is_bst, is_pre;
  logic start;
  logic rd_q, wr_q;

  always_comb begin
    op     = op_e'(cmd_op);
    is_act = (op == OP_ACT);
    is_rd  = (op == OP_RD);
    is_wr  = (op == OP_WR);
    is_bst = (op == OP_BST);
    is_pre = (op == OP_PRE);
  end

  // a column command is only honoured with the row open
  assign start = (is_rd || is_wr) && bank_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else if (start) begin
      rd_q <= is_rd;
      wr_q <= is_wr;
    end else if (is_bst || is_pre) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end
  end

  assign rd_valid = rd_q;
  assign wr_en    = wr_q;
  assign busy     = rd_q | wr_q;

  fp_col_counter #(.COL_W(COL_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .step      (busy),
    .start_col (cmd_col),
    .col       (col_addr)
  );

  fp_tras_mon #(.TRAS_MAX(TRAS_MAX)) u_tras (
    .clk    (clk),
    .rst    (rst),
    .act    (is_act),
    .pre    (is_pre),
    .open_q (bank_open),
    .err_q  (ras_err)
  );
endmodule

// File: rtl/fp_burst_chk.sv
module fp_burst_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd_op,
  input logic [COL_W-1:0] cmd_col,
  input logic [COL_W-1:0] col_addr,
  input logic             rd_valid,
  input logic             wr_en,
  input logic             busy,
  input logic             bank_open,
  input logic             ras_err
);
  // R4: uninterrupted beat advances the column by one
  a_r4_col_step: assert property (@(posedge clk) disable iff (rst)
    (busy && (cmd_op == 3'd0)) |=> (busy && col_addr == $past(col_addr) + COL_W'(1)));

  // R3: column command to an open bank loads the start column
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    ((cmd_op == 3'd2 || cmd_op == 3'd3) && bank_open) |=> (busy && col_addr == $past(cmd_col)));

  // R6: stop takes effect at the next edge
  a_r6_bst_stop: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd4) |=> (!rd_valid && !wr_en));

  // R7: precharge closes the bank and clears the error
  a_r7_pre_close: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd5) |=> (!bank_open && !busy && !ras_err));

  // R10: strobes exclusive and only with the bank open
  a_r10_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_en) && (!(rd_valid || wr_en) || bank_open));
endmodule

bind fp_burst_seq fp_burst_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_col(cmd_col),
  .col_addr(col_addr), .rd_valid(rd_valid), .wr_en(wr_en),
  .busy(busy), .bank_open(bank_open), .ras_err(ras_err)
);

// File: tb/test_fp_burst_seq.sv
module test_fp_burst_seq;
  localparam int COL_W    = 8;
  localparam int TRAS_MAX = 300;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       cmd_op = 3'd0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [COL_W-1:0] col_addr;
  logic             rd_valid, wr_en, busy, bank_open, ras_err;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;   // 250 MHz

  fp_burst_seq #(.COL_W(COL_W), .TRAS_MAX(TRAS_MAX)) i_fp_burst_seq (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_col(cmd_col),
    .col_addr(col_addr), .rd_valid(rd_valid), .wr_en(wr_en),
    .busy(busy), .bank_open(bank_open), .ras_err(ras_err)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] col;
    logic       rd;
    logic       wr;
    logic       bsy;
    logic       opn;
    logic       chk_col;
    logic [7:0] ecol;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 8'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd2},  // R2 activate
    '{3'd2, 8'd250, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd250, 4'd3},  // R3 read start
    '{3'd0, 8'd0,   1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd251, 4'd4},
    '{3'd0, 8'd0,   1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd252, 4'd4},
    '{3'd3, 8'd254, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd254, 4'd5},  // R5 abort+reload
    '{3'd0, 8'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd255, 4'd4},
    '{3'd0, 8'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd0,   4'd4},  // R4 wrap
    '{3'd4, 8'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd6},  // R6 stop
    '{3'd0, 8'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd6},
    '{3'd4, 8'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   4'd6},  // R6 idle stop
    '{3'd3, 8'd10,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd10,  4'd3},
    '{3'd5, 8'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,   4'd7},  // R7 precharge
    '{3'd2, 8'd5,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,   4'd8}   // R8 closed bank
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] col);
    @(negedge clk);
    cmd_op  = op;
    cmd_col = col;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string rq;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "outputs", {col_addr, rd_valid, wr_en, busy, bank_open, ras_err}, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].col);
      rq = $sformatf("R%0d", VECS[i].req);
      chk(rq, "rd_valid", rd_valid, VECS[i].rd);
      chk(rq, "wr_en", wr_en, VECS[i].wr);
      chk(rq, "busy", busy, VECS[i].bsy);
      chk(rq, "bank_open", bank_open, VECS[i].opn);
      if (VECS[i].chk_col) chk(rq, "col_addr", col_addr, VECS[i].ecol);
    end

    // R4 full page walk returning to start
    step(3'd1, 8'd0);
    step(3'd2, 8'd7);
    chk("R3", "col_addr", col_addr, 7);
    for (int k = 1; k <= 256; k++) begin
      step(3'd0, 8'd0);
      if (col_addr != 8'((7 + k) % 256)) chk("R4", "col_addr", col_addr, (7 + k) % 256);
    end
    chk("R4", "wrap col_addr", col_addr, 7);
    chk("R4", "busy", busy, 1);
    chk("R9", "ras_err early", ras_err, 0);   // 257 edges since ACT

    // R9 error at exactly TRAS_MAX edges
    for (int k = 0; k < TRAS_MAX - 258; k++) step(3'd0, 8'd0);
    chk("R9", "ras_err at limit-1", ras_err, 0);
    step(3'd0, 8'd0);
    chk("R9", "ras_err at limit", ras_err, 1);

    // R2 activate while open ignored
    step(3'd1, 8'd0);
    chk("R2", "ras_err kept", ras_err, 1);
    chk("R2", "bank_open", bank_open, 1);

    // R6 write stop with zero latency
    step(3'd3, 8'd3);
    step(3'd0, 8'd0);
    chk("R6", "wr_en before stop", wr_en, 1);
    step(3'd4, 8'd0);
    chk("R6", "wr_en after stop", wr_en, 0);

    // R7 precharge clears error
    step(3'd5, 8'd0);
    chk("R7", "ras_err", ras_err, 0);
    chk("R7", "bank_open", bank_open, 0);

    // R1 reset mid-burst
    step(3'd1, 8'd0);
    step(3'd2, 8'd40);
    chk("R10", "rd only", {rd_valid, wr_en}, 2);
    @(negedge clk);
    rst    = 1'b1;
    cmd_op = 3'd0;
    @(posedge clk);
    #1;
    chk("R1", "outputs after reset", {col_addr, rd_valid, wr_en, busy, bank_open, ras_err}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule